// File: doc/BRIEF.md
# Three-Processor Shared Memory with Write-Back Caches

This block models a small shared-memory subsystem. Three processors, numbered 0 to 2, each own an eight-entry direct-mapped write-back cache, and all three caches sit in front of a single sixteen-word main memory. In any clock cycle at most one processor presents a request. The request carries a processor id, an address, a read/write flag and write data. State changes take effect at that clock edge.

On a read that misses the requester's own cache, the block first looks for the line in the other two caches. Only when no peer holds the line does it fetch from main memory. The fetched word is loaded into the requester's entry. A write only touches the requester's entry and marks it dirty. Main memory receives data only when a dirty entry is displaced by a different address.

A sixteen-bit consistency vector reports, for every memory word, whether at least one cache holds the same value at the matching index.

Top module: `cache_sys_top`

## Requirements
- R1: After reset every cache entry is invalid, clean and holds data -8. Every memory word holds -16, `coherent_map` is all zeros and `rsp_done` is low.
- R2: An address selects cache index addr[2:0] and tag addr[3]. A lookup hits only when the entry is valid and its stored tag equals addr[3].
- R3: A read that hits the requester's own entry returns that entry's data with `rsp_src` = 1 (own). Cache and memory contents are unchanged.
- R4: A read that misses its own entry but hits a peer's entry returns the peer data with `rsp_src` = 2 (peer). A dirty peer is preferred over a clean one, and among equals the lower id wins. The requester's entry is loaded with that data and is dirty exactly when the data differs from the memory word at that address.
- R5: A read that hits no cache returns the memory word with `rsp_src` = 3 (memory) and loads it into the requester's entry as valid and clean.
- R6: A write stores the write data in the requester's entry at the request index, sets valid, sets dirty and stores the tag. It leaves the memory word at that address unchanged and produces no `rsp_done`.
- R7: When a fill or write displaces a valid dirty entry holding a different tag, the old data is written to memory at {old tag, index}. A clean or invalid displaced entry leaves memory untouched.
- R8: `coherent_map[A]` is high exactly when memory word A equals the data at index A mod 8 of at least one of the three caches.
- R9: Each accepted read raises `rsp_done` for one cycle, in the cycle after the request, with `rsp_data` and `rsp_src` valid. At all other times `rsp_done` is low.
- R10: A request with `req_valid` low or with `req_pid` = 3 changes no cache or memory state and produces no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A request is present this cycle |
| req_pid | input | 2 | Requesting processor id (0..2) |
| req_addr | input | 4 | Word address |
| req_rw | input | 1 | 0 = read, 1 = write |
| req_wdata | input | 8 | Signed write data |
| rsp_done | output | 1 | One-cycle read completion pulse |
| rsp_data | output | 8 | Signed data returned by the read |
| rsp_src | output | 2 | Data source: 1 own, 2 peer, 3 memory |
| coherent_map | output | 16 | Per-address consistency flags |

## Verification
A wrong tag, valid or dirty bit inside a cache does not show at once. It shows later: as a wrong `rsp_src` on a later read of the same index, or as a wrong memory value when a later read is served from memory after an eviction. Wrong data in an entry or a memory word shows within one cycle as a flipped bit of `coherent_map`. A reference model is therefore compared against the whole consistency vector every cycle. Long random request streams drive displaced lines back through memory, so that hidden dirty-bit errors surface.

// File: rtl/cs_pkg.sv
package cs_pkg;
    localparam int NPROC  = 3;
    localparam int PID_W  = 2;
    localparam int ADDR_W = 4;
    localparam int IDX_W  = 3;
    localparam int TAG_W  = ADDR_W - IDX_W;
    localparam int DATA_W = 8;
    localparam int NWORD  = 1 << ADDR_W;
    localparam int NLINE  = 1 << IDX_W;

    typedef logic signed [DATA_W-1:0] word_t;

    localparam word_t EMPTY_VAL = word_t'(-8);
    localparam word_t MEM_INIT  = word_t'(-16);

    typedef struct packed {
        logic             valid;
        logic             dirty;
        logic [TAG_W-1:0] tag;
        word_t            data;
    } line_t;

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_OWN  = 2'd1,
        SRC_PEER = 2'd2,
        SRC_MEM  = 2'd3
    } src_e;

    function automatic logic [IDX_W-1:0] idx_of(input logic [ADDR_W-1:0] a);
        return a[IDX_W-1:0];
    endfunction

    function automatic logic [TAG_W-1:0] tag_of(input logic [ADDR_W-1:0] a);
        return a[ADDR_W-1:IDX_W];
    endfunction

    function automatic line_t empty_line();
        line_t l;
        l.valid = 1'b0;
        l.dirty = 1'b0;
        l.tag   = '0;
        l.data  = EMPTY_VAL;
        return l;
    endfunction
endpackage

// File: rtl/cs_bank.sv
module cs_bank
    import cs_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       upd_en,
    input  logic [IDX_W-1:0]           upd_idx,
    input  line_t                      upd_line,
    output line_t [NLINE-1:0]          lines_o
);
    line_t [NLINE-1:0] lines_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NLINE; i++) lines_q[i] <= empty_line();
        end else if (upd_en) begin
            lines_q[upd_idx] <= upd_line;
        end
    end

    assign lines_o = lines_q;

    // R4 R5 R6: the addressed entry holds the loaded line after the edge
    assert_line_load_R5: assert property (@(posedge clk) disable iff (rst)
        upd_en |=> lines_q[$past(upd_idx)] == $past(upd_line));
endmodule

// File: rtl/cs_mem.sv
module cs_mem
    import cs_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_en,
    input  logic [ADDR_W-1:0]          wr_addr,
    input  word_t                      wr_data,
    output word_t [NWORD-1:0]          words_o
);
    word_t [NWORD-1:0] words_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NWORD; i++) words_q[i] <= MEM_INIT;
        end else if (wr_en) begin
            words_q[wr_addr] <= wr_data;
        end
    end

    assign words_o = words_q;

    // R6 R7: memory only changes through a write-back
    assert_mem_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(wr_en)) |-> $stable(words_q));
endmodule

// File: rtl/cs_route.sv
module cs_route
    import cs_pkg::*;
(
    input  line_t [NPROC-1:0][NLINE-1:0] lines_i,
    input  logic [PID_W-1:0]             pid_i,
    input  logic [ADDR_W-1:0]            addr_i,
    output logic                         hit_o,
    output word_t                        word_o
);
    logic  any_hit, dirty_hit;
    word_t any_word, dirty_word;
    line_t cand;

    always_comb begin
        any_hit    = 1'b0;
        dirty_hit  = 1'b0;
        any_word   = '0;
        dirty_word = '0;
        for (int q = 0; q < NPROC; q++) begin
            cand = lines_i[q][idx_of(addr_i)];
            if (q != int'(pid_i) && cand.valid && cand.tag == tag_of(addr_i)) begin
                if (!any_hit) begin
                    any_hit  = 1'b1;
                    any_word = cand.data;
                end
                if (cand.dirty && !dirty_hit) begin
                    dirty_hit  = 1'b1;
                    dirty_word = cand.data;
                end
            end
        end
        hit_o  = any_hit;
        word_o = dirty_hit ? dirty_word : any_word;
    end
endmodule

// File: rtl/cache_sys_top.sv
module cache_sys_top
    import cs_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    input  logic [PID_W-1:0]     req_pid,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic                 req_rw,
    input  logic [DATA_W-1:0]    req_wdata,
    output logic                 rsp_done,
    output logic [DATA_W-1:0]    rsp_data,
    output logic [1:0]           rsp_src,
    output logic [NWORD-1:0]     coherent_map
);
    line_t [NPROC-1:0][NLINE-1:0] lines;
    word_t [NWORD-1:0]            mem;

    logic               req_ok;
    logic [PID_W-1:0]   pid_s;
    logic [IDX_W-1:0]   idx;
    logic [TAG_W-1:0]   tag;
    line_t              own, new_line;
    logic               upd_en, wb_en;
    logic               peer_hit;
    word_t              peer_word, fill_data, mem_word;
    word_t              rd_data;
    src_e               rd_src;
    logic               rd_fire;

    assign req_ok   = req_valid && (int'(req_pid) < NPROC);
    assign pid_s    = req_ok ? req_pid : '0;
    assign idx      = idx_of(req_addr);
    assign tag      = tag_of(req_addr);
    assign own      = lines[pid_s][idx];
    assign mem_word = mem[req_addr];

    cs_route u_route (
        .lines_i (lines),
        .pid_i   (pid_s),
        .addr_i  (req_addr),
        .hit_o   (peer_hit),
        .word_o  (peer_word)
    );

    always_comb begin
        upd_en    = 1'b0;
        new_line  = own;
        rd_fire   = 1'b0;
        rd_data   = '0;
        rd_src    = SRC_NONE;
        fill_data = peer_hit ? peer_word : mem_word;
        if (req_ok) begin
            if (req_rw) begin
                upd_en   = 1'b1;
                new_line = '{valid: 1'b1, dirty: 1'b1, tag: tag, data: word_t'(req_wdata)};
            end else begin
                rd_fire = 1'b1;
                if (own.valid && own.tag == tag) begin
                    rd_data = own.data;
                    rd_src  = SRC_OWN;
                end else begin
                    upd_en   = 1'b1;
                    rd_data  = fill_data;
                    rd_src   = peer_hit ? SRC_PEER : SRC_MEM;
                    new_line = '{valid: 1'b1, dirty: (fill_data != mem_word),
                                 tag: tag, data: fill_data};
                end
            end
        end
        wb_en = upd_en && own.valid && own.dirty && (own.tag != tag);
    end

    for (genvar p = 0; p < NPROC; p++) begin : g_bank
        cs_bank u_bank (
            .clk      (clk),
            .rst      (rst),
            .upd_en   (upd_en && (int'(pid_s) == p)),
            .upd_idx  (idx),
            .upd_line (new_line),
            .lines_o  (lines[p])
        );
    end

    cs_mem u_mem (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wb_en),
        .wr_addr ({own.tag, idx}),
        .wr_data (own.data),
        .words_o (mem)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_done <= 1'b0;
            rsp_data <= '0;
            rsp_src  <= SRC_NONE;
        end else begin
            rsp_done <= rd_fire;
            if (rd_fire) begin
                rsp_data <= rd_data;
                rsp_src  <= rd_src;
            end
        end
    end

    always_comb begin
        for (int a = 0; a < NWORD; a++) begin
            coherent_map[a] = 1'b0;
            for (int p = 0; p < NPROC; p++) begin
                if (lines[p][a % NLINE].data == mem[a]) coherent_map[a] = 1'b1;
            end
        end
    end

    // R6: writes produce no completion pulse
    assert_write_silent_R6: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_rw) |=> !rsp_done);

    // R10: out-of-range id produces no response
    assert_bad_pid_R10: assert property (@(posedge clk) disable iff (rst)
        (req_valid && int'(req_pid) >= NPROC) |=> !rsp_done);

    // R9: every completion names a real source
    assert_done_src_R9: assert property (@(posedge clk) disable iff (rst)
        rsp_done |-> rsp_src != SRC_NONE);

    // R8: a word just fetched from memory is consistent
    assert_mem_fill_R8: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_rw && int'(req_pid) < NPROC) |=>
            (rsp_src != SRC_MEM || coherent_map[$past(req_addr)]));
endmodule

// File: tb/test_cache_sys_top.sv
`timescale 1ns/1ps
module test_cache_sys_top;
    logic       clk = 1'b0;
    logic       rst;
    logic       req_valid;
    logic [1:0] req_pid;
    logic [3:0] req_addr;
    logic       req_rw;
    logic [7:0] req_wdata;
    logic       rsp_done;
    logic [7:0] rsp_data;
    logic [1:0] rsp_src;
    logic [15:0] coherent_map;

    always #10 clk = ~clk;

    cache_sys_top i_cache_sys_top (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_pid(req_pid),
        .req_addr(req_addr), .req_rw(req_rw), .req_wdata(req_wdata),
        .rsp_done(rsp_done), .rsp_data(rsp_data), .rsp_src(rsp_src),
        .coherent_map(coherent_map)
    );

    integer tests = 0;
    integer fails = 0;
    bit     finished = 0;

    // reference model
    integer c_data [0:2][0:7];
    bit     c_val  [0:2][0:7];
    bit     c_dty  [0:2][0:7];
    integer c_tag  [0:2][0:7];
    integer m      [0:15];
    bit     e_done;
    integer e_data;
    integer e_src;
    integer rng = 32'h1234_5678;

    task automatic check(input bit ok, input string req, input string what,
                         input integer act, input integer exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int p = 0; p < 3; p++)
            for (int i = 0; i < 8; i++) begin
                c_data[p][i] = -8; c_val[p][i] = 0; c_dty[p][i] = 0; c_tag[p][i] = 0;
            end
        for (int a = 0; a < 16; a++) m[a] = -16;
        e_done = 0; e_data = 0; e_src = 0;
    endtask

    function automatic logic [15:0] model_map();
        logic [15:0] r = '0;
        for (int a = 0; a < 16; a++)
            for (int p = 0; p < 3; p++)
                if (c_data[p][a % 8] == m[a]) r[a] = 1'b1;
        return r;
    endfunction

    // evict then load entry (R7)
    task automatic model_load(input int p, input int i, input int t, input integer d, input bit dt);
        if (c_val[p][i] && c_dty[p][i] && c_tag[p][i] != t) m[c_tag[p][i]*8 + i] = c_data[p][i];
        c_val[p][i] = 1; c_dty[p][i] = dt; c_tag[p][i] = t; c_data[p][i] = d;
    endtask

    task automatic model_step(input bit v, input int p, input int a, input bit rw, input integer wd);
        int i = a % 8;
        int t = a / 8;
        int hitq = -1;
        int dq = -1;
        e_done = 0;
        if (!v || p > 2) return;
        if (rw) begin
            model_load(p, i, t, wd, 1);
            return;
        end
        e_done = 1;
        if (c_val[p][i] && c_tag[p][i] == t) begin
            e_data = c_data[p][i]; e_src = 1;
            return;
        end
        for (int q = 0; q < 3; q++)
            if (q != p && c_val[q][i] && c_tag[q][i] == t) begin
                if (hitq < 0) hitq = q;
                if (c_dty[q][i] && dq < 0) dq = q;
            end
        if (dq >= 0) hitq = dq;
        if (hitq >= 0) begin
            e_data = c_data[hitq][i]; e_src = 2;
            model_load(p, i, t, e_data, e_data != m[a]);
        end else begin
            e_data = m[a]; e_src = 3;
            model_load(p, i, t, e_data, 0);
        end
    endtask

    // called at a negedge; returns at the next negedge after checking
    task automatic step(input bit v, input int p, input int a, input bit rw, input integer wd,
                        input string req);
        req_valid = v; req_pid = 2'(p); req_addr = 4'(a); req_rw = rw; req_wdata = 8'(wd);
        model_step(v, p, a, rw, wd);
        @(negedge clk);
        check(rsp_done == e_done, req, "rsp_done", rsp_done, e_done);
        if (e_done) begin
            check($signed(rsp_data) == e_data, req, "rsp_data", $signed(rsp_data), e_data);
            check(rsp_src == 2'(e_src), req, "rsp_src", rsp_src, e_src);
        end
        check(coherent_map == model_map(), "R8", "coherent_map", coherent_map, model_map());
        req_valid = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        rst = 1; req_valid = 0; req_pid = 0; req_addr = 0; req_rw = 0; req_wdata = 0;
        model_reset();
        repeat (3) @(negedge clk);
        rst = 0;
        // R1: reset state
        check(coherent_map == 16'h0, "R1", "coherent_map", coherent_map, 0);
        check(rsp_done == 0, "R1", "rsp_done", rsp_done, 0);

        step(1, 1, 14, 0, 0,   "R1 R5 read from memory");
        step(1, 1, 14, 1, 25,  "R6 write 25");
        step(1, 1, 14, 0, 0,   "R3 own hit");
        step(1, 1, 6,  1, 0,   "R7 dirty eviction");
        step(1, 0, 14, 0, 0,   "R7 R5 written-back word from memory");
        step(1, 2, 6,  0, 0,   "R4 peer supply");
        step(1, 2, 6,  0, 0,   "R3 R2 own hit after peer fill");
        step(1, 2, 0,  1, 0,   "R6 write addr 0");
        step(1, 0, 15, 0, 0,   "R5 R2 index 7");
        step(1, 2, 0,  0, 0,   "R3 read own dirty");
        step(1, 1, 4,  0, 0,   "R5 read addr 4");
        step(1, 2, 4,  1, 23,  "R6 write 23");
        step(1, 0, 4,  0, 0,   "R4 dirty peer preferred");
        step(1, 2, 12, 0, 0,   "R7 R2 tag mismatch eviction");
        step(1, 0, 7,  0, 0,   "R7 clean eviction");
        step(1, 3, 0,  1, 99,  "R10 bad pid write");
        step(1, 3, 5,  0, 0,   "R10 bad pid read");
        step(0, 0, 0,  1, 77,  "R10 idle write");
        step(1, 1, 0,  0, 0,   "R10 R4 state unchanged");
        step(0, 0, 0,  0, 0,   "R9 no pulse when idle");

        for (int n = 0; n < 3000; n++) begin
            int p, a, rw, wd, vv;
            rng = rng ^ (rng << 13); rng = rng ^ (rng >>> 17); rng = rng ^ (rng << 5);
            p  = (rng >>> 3) & 3;
            a  = (rng >>> 7) & 15;
            rw = (rng >>> 12) & 1;
            wd = ((rng >>> 16) & 255) - 128;
            vv = ((rng >>> 25) & 7) != 0;
            step(vv[0], p, a, rw[0], wd, "R2 R4 R5 R7 R9 random");
        end

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule